// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Engine

This block is the device side of a byte-wide serial EEPROM. The chip select, serial clock, data-in, hold and write-protect pins enter a single system clock domain. There they are registered and edge-detected. A controller state machine then decodes six commands:

- set the write-enable latch
- clear the write-enable latch
- read the status byte
- write the status byte
- read the array
- write the array

Array writes collect up to one page of bytes in a page buffer. When chip select rises on a byte boundary, a self-timed commit starts. It lasts `WRITE_CYCLES` system clocks and copies the buffered bytes into the array, skipping any byte that falls in a protected region.

The array is a plain register array of 2^`ADDR_W` bytes, and every byte resets to 0xFF. Two address bytes follow a read or write command, and only the low `ADDR_W` bits are used. The full-size part needs `ADDR_W` = 15. The default of 11 keeps elaboration small. The SPI clock must be slower than the system clock, with each half period lasting at least four system clocks.

Controller states and transitions:

- **ST_IDLE:** chip select is high.
- **ST_IDLE → ST_OPC:** chip select falls.
- **ST_OPC:** the first byte is decoded, leading to one of:
  - **ST_RSTAT:** status read.
  - **ST_ADDR:** array read or array write.
  - **ST_WSTAT:** status write.
  - **ST_WEN / ST_WDIS:** latch set or latch clear.
  - **ST_SKIP:** an unknown or refused command.
- **ST_ADDR → ST_RDATA or ST_WDATA:** after the second address byte.
- **ST_WEN / ST_WDIS → ST_SKIP:** if another full byte arrives.
- **Any state → ST_IDLE:** chip select rises. The actions tied to ST_WEN, ST_WDIS, ST_WSTAT and ST_WDATA take effect at that moment.

Top module: `spi_eeprom_dev`

## Requirements
- R1: SI is sampled on each rising SCK edge and SO changes after each falling SCK edge. Transfers work with SCK idling low (mode 0) and with SCK idling high (mode 3) when chip select falls.
- R2: The first byte is a command of the form 0000_X_abc, where bit 3 is ignored. The abc values are: 101 status read, 001 status write, 011 array read, 010 array write, 100 latch clear, 110 latch set. A command byte with any of bits 7:4 set is ignored.
- R3: A latch-set or latch-clear command takes effect only when chip select rises right after its 8 bits. An array write or status write is accepted only while the latch is 1.
- R4: The status byte reads as bit 0 = write cycle in progress, bit 1 = write-enable latch, bits 3:2 = protection level, and bits 7:4 and unused bits = 0. A status read repeats the current status for as many bytes as are clocked.
- R5: A status write whose chip select rises on a byte boundary after at least one data byte loads the protection level from data bits 3:2. It also starts a write cycle.
- R6: Protection level 01 protects the top quarter of the array, 10 the top half, and 11 the whole array. A byte written to a protected address keeps its old value.
- R7: An array read returns the byte at the given address, then the following addresses. After the highest address it continues at address 0. Address bits above ADDR_W are ignored.
- R8: An array write carries 1 to 64 bytes. Within a transfer, the byte offset wraps inside its 64-byte page. Nothing is committed unless chip select rises on a byte boundary after at least one data byte.
- R9: A committed write keeps the busy bit at 1 for WRITE_CYCLES system clocks, and the write-enable latch clears when the cycle ends.
- R10: While busy, only the status read is honoured. Array reads drive no data, and other commands have no effect.
- R11: With wp_n low, array writes and status writes are refused.
- R12: While hold_n is low during a transfer, SCK edges are ignored and SO is not driven. The transfer resumes where it stopped when hold_n returns high.
- R13: After reset the status byte is 0x00, every array byte reads 0xFF, and SO is not driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Suspend request, active low |
| wp_n | input | 1 | Hardware write protect, active low |
| so | output | 1 | Serial data to the host |
| so_en | output | 1 | Output enable for so (high = driven) |

## Verification
A wrong write-enable latch or busy bit shows up in the very next status read. It also shows one transfer later, as a write that lands when it should have been refused, or one that is dropped when it should land. A wrong protection level or page offset remains in the array until it is read back. A read of the affected address exposes it in the first data byte. A wrong bit counter or address register shifts or corrupts the serial output within the same byte. A hold or busy fault appears within a few system clocks as so_en driven when it must stay low.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_RDATA,
        ST_RSTAT,
        ST_WDATA,
        ST_WSTAT,
        ST_WEN,
        ST_WDIS,
        ST_SKIP
    } ee_state_e;

    // low three bits of the command byte
    localparam logic [2:0] CMD_STAT_RD = 3'b101;
    localparam logic [2:0] CMD_STAT_WR = 3'b001;
    localparam logic [2:0] CMD_ARR_RD  = 3'b011;
    localparam logic [2:0] CMD_ARR_WR  = 3'b010;
    localparam logic [2:0] CMD_WEL_CLR = 3'b100;
    localparam logic [2:0] CMD_WEL_SET = 3'b110;

    // top2 = two most significant array address bits
    function automatic logic in_protected(input logic [1:0] lvl, input logic [1:0] top2);
        logic hit;
        unique case (lvl)
            2'b00: hit = 1'b0;
            2'b01: hit = (top2 == 2'b11);
            2'b10: hit = top2[1];
            default: hit = 1'b1;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/spi_ee_pins.sv
module spi_ee_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic sel,
    output logic sel_rise,
    output logic sel_fall,
    output logic clk_rise,
    output logic clk_fall,
    output logic din,
    output logic held,
    output logic wp_on
);

    logic cs_s, cs_d, sck_s, sck_d, si_s, hold_s, wp_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_s   <= 1'b1;
            cs_d   <= 1'b1;
            sck_s  <= 1'b0;
            sck_d  <= 1'b0;
            si_s   <= 1'b0;
            hold_s <= 1'b1;
            wp_s   <= 1'b1;
        end else begin
            cs_s   <= cs_n;
            cs_d   <= cs_s;
            sck_s  <= sck;
            sck_d  <= sck_s;
            si_s   <= si;
            hold_s <= hold_n;
            wp_s   <= wp_n;
        end
    end

    always_comb begin
        sel      = !cs_s;
        sel_fall = !cs_s && cs_d;
        sel_rise = cs_s && !cs_d;
        held     = sel && !hold_s;
        clk_rise = sel && !held && sck_s && !sck_d;
        clk_fall = sel && !held && !sck_s && sck_d;
        din      = si_s;
        wp_on    = !wp_s;
    end

endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= 8'hFF;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/spi_ee_commit.sv
module spi_ee_commit
    import spi_ee_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int PAGE_W       = 6,
    parameter int WRITE_CYCLES = 1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     buf_we,
    input  logic [PAGE_W-1:0]        buf_idx,
    input  logic [7:0]               buf_data,
    input  logic                     buf_clr,
    input  logic                     start_data,
    input  logic                     start_stat,
    input  logic [ADDR_W-PAGE_W-1:0] page_base,
    input  logic [1:0]               prot_lvl,
    output logic                     busy,
    output logic                     cycle_done,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [7:0]               mem_wdata
);

    localparam int PAGE = 1 << PAGE_W;
    localparam int CNT_W = $clog2(WRITE_CYCLES);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(WRITE_CYCLES - 1);
    localparam logic [CNT_W-1:0] PG_LIM = CNT_W'(PAGE);
    localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);

    logic [7:0]               pg_data [PAGE];
    logic [PAGE-1:0]          pg_vld;
    logic [CNT_W-1:0]         cnt_q;
    logic                     data_mode_q;
    logic [ADDR_W-PAGE_W-1:0] base_q;
    logic [PAGE_W-1:0]        idx;
    logic                     start_any;

    assign start_any = start_data || start_stat;

    always_ff @(posedge clk) begin
        if (buf_we) begin
            pg_data[buf_idx] <= buf_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_vld      <= '0;
            busy        <= 1'b0;
            cnt_q       <= '0;
            data_mode_q <= 1'b0;
            base_q      <= '0;
        end else begin
            if (buf_clr) begin
                pg_vld <= '0;
            end else if (buf_we) begin
                pg_vld[buf_idx] <= 1'b1;
            end
            if (start_any && !busy) begin
                busy        <= 1'b1;
                cnt_q       <= '0;
                data_mode_q <= start_data;
                base_q      <= page_base;
            end else if (busy) begin
                if (cnt_q == LAST) begin
                    busy <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + C_ONE;
                end
            end
        end
    end

    always_comb begin
        idx        = cnt_q[PAGE_W-1:0];
        mem_addr   = {base_q, idx};
        mem_wdata  = pg_data[idx];
        cycle_done = busy && (cnt_q == LAST);
        mem_we     = busy && data_mode_q && (cnt_q < PG_LIM) && pg_vld[idx]
                     && !in_protected(prot_lvl, mem_addr[ADDR_W-1 -: 2]);
    end

    // R9: a busy period only ever begins from a commit request
    p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_any));

    // R8: the buffer is never reloaded during a commit
    p_no_fill_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_we);

endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
    import spi_ee_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel,
    input  logic                     sel_rise,
    input  logic                     sel_fall,
    input  logic                     clk_rise,
    input  logic                     clk_fall,
    input  logic                     din,
    input  logic                     held,
    input  logic                     wp_on,
    input  logic                     busy,
    input  logic                     cycle_done,
    input  logic [7:0]               rd_data,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic                     so,
    output logic                     so_en,
    output logic                     buf_we,
    output logic [PAGE_W-1:0]        buf_idx,
    output logic [7:0]               buf_data,
    output logic                     buf_clr,
    output logic                     start_data,
    output logic                     start_stat,
    output logic [ADDR_W-PAGE_W-1:0] page_base,
    output logic [1:0]               prot_lvl
);

    localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
    localparam logic [PAGE_W-1:0] P_ONE = PAGE_W'(1);

    ee_state_e   st, st_nx;
    logic [2:0]  bit_q;
    logic [6:0]  sh_q;
    logic [15:0] addr_q;
    logic        addr_lo_q, is_rd_q, ld_q, so_q, wel_q, got_q;
    logic [7:0]  tx_q;
    logic [1:0]  bp_q, bp_new_q;
    logic        byte_done, may_write, hi_ok, out_phase;
    logic [7:0]  byte_val, status_w;
    logic [2:0]  cmd;

    always_comb begin
        byte_done = clk_rise && (bit_q == 3'd7);
        byte_val  = {sh_q, din};
        cmd       = byte_val[2:0];
        hi_ok     = (byte_val[7:4] == 4'h0);
        status_w  = {4'h0, bp_q, wel_q, busy};
        may_write = wel_q && !wp_on && !busy;
        out_phase = (st == ST_RDATA) || (st == ST_RSTAT);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        if (!sel) begin
            st_nx = ST_IDLE;
        end else if (sel_fall) begin
            st_nx = ST_OPC;
        end else if (byte_done) begin
            unique case (st)
                ST_OPC: begin
                    if (!hi_ok) begin
                        st_nx = ST_SKIP;
                    end else begin
                        case (cmd)
                            CMD_STAT_RD: st_nx = ST_RSTAT;
                            CMD_ARR_RD:  st_nx = busy ? ST_SKIP : ST_ADDR;
                            CMD_ARR_WR:  st_nx = may_write ? ST_ADDR : ST_SKIP;
                            CMD_STAT_WR: st_nx = may_write ? ST_WSTAT : ST_SKIP;
                            CMD_WEL_SET: st_nx = busy ? ST_SKIP : ST_WEN;
                            CMD_WEL_CLR: st_nx = busy ? ST_SKIP : ST_WDIS;
                            default:     st_nx = ST_SKIP;
                        endcase
                    end
                end
                ST_ADDR: begin
                    if (addr_lo_q) st_nx = is_rd_q ? ST_RDATA : ST_WDATA;
                end
                ST_WEN, ST_WDIS: st_nx = ST_SKIP;
                default: st_nx = st;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q     <= '0;
            sh_q      <= '0;
            addr_q    <= '0;
            addr_lo_q <= 1'b0;
            is_rd_q   <= 1'b0;
            ld_q      <= 1'b0;
            tx_q      <= '0;
            so_q      <= 1'b0;
            wel_q     <= 1'b0;
            got_q     <= 1'b0;
            bp_q      <= '0;
            bp_new_q  <= '0;
        end else begin
            ld_q <= 1'b0;
            if (sel_fall) begin
                bit_q     <= '0;
                sh_q      <= '0;
                addr_lo_q <= 1'b0;
                got_q     <= 1'b0;
            end else if (clk_rise) begin
                sh_q  <= {sh_q[5:0], din};
                bit_q <= bit_q + 3'd1;
            end
            if (ld_q) begin
                tx_q <= (st == ST_RSTAT) ? status_w : rd_data;
            end
            if (byte_done) begin
                case (st)
                    ST_OPC: begin
                        is_rd_q <= (cmd == CMD_ARR_RD);
                        if (st_nx == ST_RSTAT) ld_q <= 1'b1;
                    end
                    ST_ADDR: begin
                        addr_q    <= {addr_q[7:0], byte_val};
                        addr_lo_q <= 1'b1;
                        if (addr_lo_q && is_rd_q) ld_q <= 1'b1;
                    end
                    ST_RDATA: begin
                        addr_q[ADDR_W-1:0] <= addr_q[ADDR_W-1:0] + A_ONE;
                        ld_q <= 1'b1;
                    end
                    ST_RSTAT: ld_q <= 1'b1;
                    ST_WDATA: begin
                        addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + P_ONE;
                        got_q <= 1'b1;
                    end
                    ST_WSTAT: begin
                        if (!got_q) begin
                            bp_new_q <= byte_val[3:2];
                            got_q    <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (clk_fall && out_phase) begin
                so_q <= tx_q[3'd7 - bit_q];
            end
            if (cycle_done) begin
                wel_q <= 1'b0;
            end else if (sel_rise && bit_q == 3'd0) begin
                if (st == ST_WEN)  wel_q <= 1'b1;
                if (st == ST_WDIS) wel_q <= 1'b0;
            end
            if (start_stat) begin
                bp_q <= bp_new_q;
            end
        end
    end

    always_comb begin
        so         = so_q;
        so_en      = sel && !held && out_phase;
        rd_addr    = addr_q[ADDR_W-1:0];
        buf_we     = byte_done && (st == ST_WDATA);
        buf_idx    = addr_q[PAGE_W-1:0];
        buf_data   = byte_val;
        buf_clr    = byte_done && (st == ST_OPC) && (st_nx == ST_ADDR) && (cmd == CMD_ARR_WR);
        start_data = sel_rise && (st == ST_WDATA) && (bit_q == 3'd0) && got_q;
        start_stat = sel_rise && (st == ST_WSTAT) && (bit_q == 3'd0) && got_q;
        page_base  = addr_q[ADDR_W-1:PAGE_W];
        prot_lvl   = bp_q;
    end

    // R3: a commit is requested only with the latch set and no cycle running
    p_start_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_data || start_stat) |-> (wel_q && !busy));

    // R9: the end of a write cycle leaves the latch cleared
    p_wel_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !wel_q);

    // R10: no array transfer phase exists while busy
    p_busy_no_array_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st != ST_RDATA && st != ST_WDATA));

    // R1: each transfer starts its bit count from zero
    p_bit_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_fall |=> (bit_q == 3'd0));

    // R12: no serial clock edge is accepted while held
    p_hold_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> $stable(bit_q));

endmodule

// File: rtl/spi_eeprom_dev.sv
module spi_eeprom_dev #(
    parameter int ADDR_W       = 11,
    parameter int PAGE_W       = 6,
    parameter int WRITE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic so,
    output logic so_en
);

    logic sel, sel_rise, sel_fall, clk_rise, clk_fall, din, held, wp_on;
    logic busy, cycle_done, buf_we, buf_clr, start_data, start_stat, mem_we;
    logic [PAGE_W-1:0]        buf_idx;
    logic [7:0]               buf_data, rd_data, mem_wdata;
    logic [ADDR_W-PAGE_W-1:0] page_base;
    logic [1:0]               prot_lvl;
    logic [ADDR_W-1:0]        rd_addr, mem_addr;

    spi_ee_pins pins_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .sel(sel), .sel_rise(sel_rise),
        .sel_fall(sel_fall), .clk_rise(clk_rise), .clk_fall(clk_fall),
        .din(din), .held(held), .wp_on(wp_on)
    );

    spi_ee_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sel_rise(sel_rise),
        .sel_fall(sel_fall), .clk_rise(clk_rise), .clk_fall(clk_fall),
        .din(din), .held(held), .wp_on(wp_on), .busy(busy),
        .cycle_done(cycle_done), .rd_data(rd_data), .rd_addr(rd_addr),
        .so(so), .so_en(so_en), .buf_we(buf_we), .buf_idx(buf_idx),
        .buf_data(buf_data), .buf_clr(buf_clr), .start_data(start_data),
        .start_stat(start_stat), .page_base(page_base), .prot_lvl(prot_lvl)
    );

    spi_ee_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) commit_i (
        .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_idx(buf_idx),
        .buf_data(buf_data), .buf_clr(buf_clr), .start_data(start_data),
        .start_stat(start_stat), .page_base(page_base), .prot_lvl(prot_lvl),
        .busy(busy), .cycle_done(cycle_done), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    spi_ee_array #(.ADDR_W(ADDR_W)) array_i (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_addr),
        .wdata(mem_wdata), .raddr(rd_addr), .rdata(rd_data)
    );

endmodule

// File: tb/spi_eeprom_dev_tb.sv
module spi_eeprom_dev_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_en;
    logic mode3 = 1'b0;
    int   nchk = 0;
    int   nerr = 0;
    bit   ended = 1'b0;

    always #2 clk = ~clk;

    spi_eeprom_dev #(.ADDR_W(11), .PAGE_W(6), .WRITE_CYCLES(800)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_en(so_en)
    );

    // {level, mode3, write addr, read addr, data, expected}
    localparam logic [50:0] VEC [8] = '{
        {2'd0, 1'b0, 16'h0010, 16'h0010, 8'h5A, 8'h5A},
        {2'd0, 1'b1, 16'h0123, 16'h0123, 8'hC3, 8'hC3},
        {2'd1, 1'b0, 16'h0700, 16'h0700, 8'h11, 8'hFF},
        {2'd1, 1'b1, 16'h0500, 16'h0500, 8'h22, 8'h22},
        {2'd2, 1'b0, 16'h0480, 16'h0480, 8'h33, 8'hFF},
        {2'd2, 1'b1, 16'h03FF, 16'h03FF, 8'h44, 8'h44},
        {2'd3, 1'b0, 16'h0002, 16'h0002, 8'h55, 8'hFF},
        {2'd0, 1'b1, 16'h8005, 16'h0005, 8'h66, 8'h66}
    };

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwait();
        repeat (5) @(negedge clk);
    endtask

    task automatic sel_on();
        sck = mode3;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        hwait();
    endtask

    task automatic sel_off();
        hwait();
        if (!mode3) sck = 1'b0;
        hwait();
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic bits(input int n, input logic [7:0] tx, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < n; i++) begin
            sck = 1'b0;
            si = tx[7-i];
            hwait();
            rx = {rx[6:0], so};
            sck = 1'b1;
            hwait();
        end
    endtask

    task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
        bits(8, tx, rx);
    endtask

    task automatic cmd_only(input logic [7:0] op);
        logic [7:0] d;
        sel_on();
        xb(op, d);
        sel_off();
    endtask

    task automatic stat_rd(output logic [7:0] s);
        logic [7:0] d;
        sel_on();
        xb(8'h05, d);
        xb(8'h00, s);
        sel_off();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 30; k++) begin
            stat_rd(s);
            if (!s[0]) break;
        end
    endtask

    task automatic wr_raw(input logic [15:0] a, input logic [7:0] v);
        logic [7:0] d;
        sel_on();
        xb(8'h02, d);
        xb(a[15:8], d);
        xb(a[7:0], d);
        xb(v, d);
        sel_off();
    endtask

    task automatic wr_stat(input logic [1:0] lvl);
        logic [7:0] d;
        cmd_only(8'h06);
        sel_on();
        xb(8'h01, d);
        xb({4'h0, lvl, 2'b00}, d);
        sel_off();
        wait_idle();
    endtask

    task automatic wr_byte(input logic [15:0] a, input logic [7:0] v);
        cmd_only(8'h06);
        wr_raw(a, v);
        wait_idle();
    endtask

    task automatic rd_byte(input logic [7:0] op, input logic [15:0] a, output logic [7:0] v);
        logic [7:0] d;
        sel_on();
        xb(op, d);
        xb(a[15:8], d);
        xb(a[7:0], d);
        xb(8'h00, v);
        sel_off();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] s, v, w;
        logic [1:0] lvl;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R13 reset state
        check8("R13 so_en idle", {7'd0, so_en}, 8'h00);
        stat_rd(s);
        check8("R13 status after reset", s, 8'h00);
        rd_byte(8'h03, 16'h0100, v);
        check8("R13 array after reset", v, 8'hFF);

        // R3 latch set / clear
        cmd_only(8'h06);
        stat_rd(s);
        check8("R3 latch set", s, 8'h02);
        cmd_only(8'h04);
        stat_rd(s);
        check8("R3 latch clear", s, 8'h00);

        // R2 upper nibble set: ignored
        cmd_only(8'h16);
        stat_rd(s);
        check8("R2 bad command ignored", s, 8'h00);

        // R3 write without latch refused
        wr_raw(16'h0200, 8'h77);
        stat_rd(s);
        check8("R3 no busy without latch", s, 8'h00);
        rd_byte(8'h03, 16'h0200, v);
        check8("R3 unlatched write dropped", v, 8'hFF);

        // vector table: R1 modes, R2 bit3, R5 status write, R6 protection, R7 upper bits
        for (int i = 0; i < 8; i++) begin
            lvl   = VEC[i][50:49];
            mode3 = VEC[i][48];
            wr_stat(lvl);
            stat_rd(s);
            check8("R5 protection level loaded", s, {4'h0, lvl, 2'b00});
            wr_byte(VEC[i][47:32], VEC[i][15:8]);
            rd_byte(mode3 ? 8'h0B : 8'h03, VEC[i][31:16], v);
            check8("R6 R1 R7 vector readback", v, VEC[i][7:0]);
        end
        mode3 = 1'b0;

        // R9 / R10 busy behaviour
        cmd_only(8'h06);
        wr_raw(16'h0040, 8'hA5);
        stat_rd(s);
        check8("R9 busy with latch", s, 8'h03);
        sel_on();
        xb(8'h03, v);
        xb(8'h00, v);
        xb(8'h40, v);
        hwait();
        check8("R10 no read data while busy", {7'd0, so_en}, 8'h00);
        sel_off();
        wait_idle();
        stat_rd(s);
        check8("R9 latch cleared after cycle", s, 8'h00);
        rd_byte(8'h03, 16'h0040, v);
        check8("R9 committed byte", v, 8'hA5);

        // R8 page wrap
        cmd_only(8'h06);
        sel_on();
        xb(8'h02, v);
        xb(8'h01, v);
        xb(8'h3E, v);
        xb(8'hA1, v);
        xb(8'hB2, v);
        xb(8'hC3, v);
        sel_off();
        wait_idle();
        rd_byte(8'h03, 16'h013E, v);
        check8("R8 page offset 62", v, 8'hA1);
        rd_byte(8'h03, 16'h013F, v);
        check8("R8 page offset 63", v, 8'hB2);
        rd_byte(8'h03, 16'h0100, v);
        check8("R8 page wrap to offset 0", v, 8'hC3);

        // R8 partial byte: no commit
        cmd_only(8'h06);
        sel_on();
        xb(8'h02, v);
        xb(8'h03, v);
        xb(8'h00, v);
        xb(8'h99, v);
        bits(4, 8'hF0, v);
        sel_off();
        stat_rd(s);
        check8("R8 partial byte no busy", s, 8'h02);
        rd_byte(8'h03, 16'h0300, v);
        check8("R8 partial byte no commit", v, 8'hFF);
        cmd_only(8'h04);

        // R11 hardware protect
        wp_n = 1'b0;
        cmd_only(8'h06);
        wr_raw(16'h0310, 8'h12);
        stat_rd(s);
        check8("R11 write refused", s, 8'h02);
        rd_byte(8'h03, 16'h0310, v);
        check8("R11 array unchanged", v, 8'hFF);
        sel_on();
        xb(8'h01, v);
        xb(8'h0C, v);
        sel_off();
        stat_rd(s);
        check8("R11 status write refused", s, 8'h02);
        wp_n = 1'b1;
        cmd_only(8'h04);

        // R7 rollover and R4 repeated status
        wr_byte(16'h07FF, 8'h9E);
        wr_byte(16'h0000, 8'h81);
        sel_on();
        xb(8'h03, v);
        xb(8'h07, v);
        xb(8'hFF, v);
        xb(8'h00, v);
        xb(8'h00, w);
        sel_off();
        check8("R7 top address", v, 8'h9E);
        check8("R7 rollover to 0", w, 8'h81);
        cmd_only(8'h06);
        sel_on();
        xb(8'h05, v);
        xb(8'h00, v);
        xb(8'h00, w);
        sel_off();
        check8("R4 status first byte", v, 8'h02);
        check8("R4 status repeated", w, 8'h02);
        cmd_only(8'h04);

        // R12 hold
        sel_on();
        xb(8'h03, v);
        xb(8'h00, v);
        xb(8'h10, v);
        sck = 1'b0;
        hwait();
        hold_n = 1'b0;
        hwait();
        hwait();
        check8("R12 so_en off in hold", {7'd0, so_en}, 8'h00);
        for (int k = 0; k < 3; k++) begin
            sck = 1'b1;
            si = 1'b1;
            hwait();
            sck = 1'b0;
            hwait();
        end
        hold_n = 1'b1;
        hwait();
        xb(8'h00, v);
        sel_off();
        check8("R12 data after hold", v, 8'h5A);

        finish_run();
    end

endmodule